// File: doc/BRIEF.md
# Link Fault Column Reporter

This block sits on a four-lane receive path. Each lane carries one byte per clock and two side bits. It reports link faults to the layer above. When the block sees a local fault condition of its own, it replaces the outgoing column with the local fault column. A local fault condition is loss of signal, or any other internal fault source. Columns that come in from the line or the transmit bus are always forwarded untouched, whether they carry a local or a remote fault code. The higher layer's fault state machine interprets them, and this block never regenerates them.

The block also keeps a latched local-fault flag for each of two management register mirrors, one per device address. The flag sits at bit 7 of a 16-bit status word. A read strobe for a mirror clears that mirror's flag, unless a fault is present in the read cycle. A fault column received on the input also counts as a local fault for the status flags, provided all four lanes match the pattern in the same column.

Top module: `link_fault_reporter`

## Requirements
- R1: While reset is high, every output port reads zero. This covers the lane data, the side bits and both status words.
- R2: When loss of signal is high in a cycle, the output in the next cycle is the local fault column. Lane 0 (data bits 7:0, side bits 1:0) carries 0x9C with both side bits 1. Lanes 1 and 2 carry 0x00 with side bits 00. Lane 3 (data bits 31:24, side bits 7:6) carries 0x01 with side bits 00.
- R3: When no local fault condition is present in a cycle, the next cycle's output data and side bits equal that cycle's input. This holds for received remote fault columns (lane 3 code 0x02) and for received local fault columns.
- R4: A received column that matches the local fault column of R2 on all four lanes sets bit 7 of both status words in the next cycle. A received remote fault column does not set them.
- R5: A high bit on any auxiliary internal fault input acts exactly like loss of signal, for both the output column and the status flags.
- R6: Once set, bit 7 of a status word stays set until that mirror's read strobe is seen.
- R7: In a cycle where a mirror's read strobe is high, that mirror's bit 7 becomes, in the next cycle, the fault condition of the read cycle. The other mirror is unaffected.
- R8: All status word bits other than bit 7 are always zero.
- R9: A column that differs from the local fault pattern in any single lane byte or side bit is not recognised and does not set the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data_i | input | 32 | Four input lane bytes, lane k at bits 8k+7:8k |
| rx_side_i | input | 8 | Two side bits per lane, lane k at bits 2k+1:2k |
| los_i | input | 1 | Loss-of-signal indication |
| aux_fault_i | input | AUX_W | Other internal fault sources |
| rd_dev_a_i | input | 1 | Read strobe for status mirror A |
| rd_dev_b_i | input | 1 | Read strobe for status mirror B |
| out_data_o | output | 32 | Output lane bytes, same layout as input |
| out_side_o | output | 8 | Output side bits, same layout as input |
| status_dev_a_o | output | REG_W | Status word A, latched fault at bit 7 |
| status_dev_b_o | output | REG_W | Status word B, latched fault at bit 7 |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. This covers the substituted or forwarded column, the setting of a status flag by a fault, and the clearing or holding of a flag after a read. The bench drives each input set at a falling edge. It samples the outputs at the next falling edge, one rising edge later, and compares them with values computed from the inputs it has just applied and from its own copy of the two flags. A failure is tagged with the requirement that matches the stimulus: a read, a received column, a near-miss column, an auxiliary fault or loss of signal.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int SIDE_W = 2;
  localparam int LANE_W = BYTE_W + SIDE_W;

  localparam logic [BYTE_W-1:0] SEQ_CHAR    = 8'h9C;
  localparam logic [BYTE_W-1:0] CODE_LOCAL  = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_REMOTE = 8'h02;

  // {side[1:0], data[7:0]} expected on a lane of a fault column
  function automatic logic [LANE_W-1:0] fault_lane(input int idx, input logic [BYTE_W-1:0] code);
    logic [LANE_W-1:0] v;
    if (idx == 0)              v = {2'b11, SEQ_CHAR};
    else if (idx == LANES - 1) v = {2'b00, code};
    else                       v = '0;
    return v;
  endfunction
endpackage

// File: rtl/lfr_col_detect.sv
module lfr_col_detect
  import lfr_pkg::*;
(
  input  logic [LANES*BYTE_W-1:0] data_i,
  input  logic [LANES*SIDE_W-1:0] side_i,
  output logic                    is_local_o
);
  logic [LANES-1:0] lane_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LANE_W-1:0] TMPL = fault_lane(l, CODE_LOCAL);
    logic [LANE_W-1:0] lane_v;
    assign lane_v      = {side_i[l*SIDE_W +: SIDE_W], data_i[l*BYTE_W +: BYTE_W]};
    assign lane_hit[l] = (lane_v == TMPL);
  end

  assign is_local_o = &lane_hit;
endmodule

// File: rtl/lfr_col_mux.sv
module lfr_col_mux
  import lfr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    subst_i,
  input  logic [LANES*BYTE_W-1:0] data_i,
  input  logic [LANES*SIDE_W-1:0] side_i,
  output logic [LANES*BYTE_W-1:0] data_o,
  output logic [LANES*SIDE_W-1:0] side_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LANE_W-1:0] TMPL = fault_lane(l, CODE_LOCAL);
    always_ff @(posedge clk) begin
      if (rst) begin
        data_o[l*BYTE_W +: BYTE_W] <= '0;
        side_o[l*SIDE_W +: SIDE_W] <= '0;
      end else if (subst_i) begin
        data_o[l*BYTE_W +: BYTE_W] <= TMPL[BYTE_W-1:0];
        side_o[l*SIDE_W +: SIDE_W] <= TMPL[LANE_W-1:BYTE_W];
      end else begin
        data_o[l*BYTE_W +: BYTE_W] <= data_i[l*BYTE_W +: BYTE_W];
        side_o[l*SIDE_W +: SIDE_W] <= side_i[l*SIDE_W +: SIDE_W];
      end
    end
  end
endmodule

// File: rtl/lfr_stat_latch.sv
module lfr_stat_latch #(
  parameter int REG_W    = 16,
  parameter int FLAG_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] word_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (rd_i) flag_q <= set_i;
    else           flag_q <= flag_q | set_i;
  end

  always_comb begin
    word_o           = '0;
    word_o[FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/link_fault_reporter.sv
module link_fault_reporter
  import lfr_pkg::*;
#(
  parameter int AUX_W    = 2,
  parameter int REG_W    = 16,
  parameter int FLAG_BIT = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*BYTE_W-1:0] rx_data_i,
  input  logic [LANES*SIDE_W-1:0] rx_side_i,
  input  logic                    los_i,
  input  logic [AUX_W-1:0]        aux_fault_i,
  input  logic                    rd_dev_a_i,
  input  logic                    rd_dev_b_i,
  output logic [LANES*BYTE_W-1:0] out_data_o,
  output logic [LANES*SIDE_W-1:0] out_side_o,
  output logic [REG_W-1:0]        status_dev_a_o,
  output logic [REG_W-1:0]        status_dev_b_o
);
  localparam int MIRRORS = 2;

  logic             local_cond;
  logic             rx_local_col;
  logic             flag_set;
  logic [MIRRORS-1:0] rd_vec;
  logic [REG_W-1:0] words [MIRRORS];

  assign local_cond = los_i | (|aux_fault_i);

  lfr_col_detect u_det (
    .data_i     (rx_data_i),
    .side_i     (rx_side_i),
    .is_local_o (rx_local_col)
  );

  lfr_col_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .subst_i (local_cond),
    .data_i  (rx_data_i),
    .side_i  (rx_side_i),
    .data_o  (out_data_o),
    .side_o  (out_side_o)
  );

  assign flag_set = local_cond | rx_local_col;
  assign rd_vec   = {rd_dev_b_i, rd_dev_a_i};

  for (genvar m = 0; m < MIRRORS; m++) begin : g_mirror
    lfr_stat_latch #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_lat (
      .clk    (clk),
      .rst    (rst),
      .set_i  (flag_set),
      .rd_i   (rd_vec[m]),
      .word_o (words[m])
    );
  end

  assign status_dev_a_o = words[0];
  assign status_dev_b_o = words[1];
endmodule

// File: rtl/lfr_chk.sv
module lfr_chk #(
  parameter int AUX_W    = 2,
  parameter int REG_W    = 16,
  parameter int FLAG_BIT = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      rx_data_i,
  input logic [7:0]       rx_side_i,
  input logic             los_i,
  input logic [AUX_W-1:0] aux_fault_i,
  input logic             rd_dev_a_i,
  input logic             rd_dev_b_i,
  input logic [31:0]      out_data_o,
  input logic [7:0]       out_side_o,
  input logic [REG_W-1:0] status_dev_a_o,
  input logic [REG_W-1:0] status_dev_b_o
);
  localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(1) << FLAG_BIT;

  AST_LF_COLUMN: assert property (@(posedge clk) disable iff (rst)
    los_i |=> (out_data_o == 32'h0100009C && out_side_o == 8'h03)); // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (!los_i && aux_fault_i == '0) |=> (out_data_o == $past(rx_data_i) && out_side_o == $past(rx_side_i))); // R3
  AST_RX_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (rx_data_i == 32'h0100009C && rx_side_i == 8'h03) |=> (status_dev_a_o[FLAG_BIT] && status_dev_b_o[FLAG_BIT])); // R4
  AST_AUX_SET: assert property (@(posedge clk) disable iff (rst)
    (aux_fault_i != '0) |=> (status_dev_a_o[FLAG_BIT] && status_dev_b_o[FLAG_BIT])); // R5
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    (status_dev_a_o[FLAG_BIT] && !rd_dev_a_i) |=> status_dev_a_o[FLAG_BIT]); // R6
  AST_CLR_A: assert property (@(posedge clk) disable iff (rst)
    (rd_dev_a_i && !los_i && aux_fault_i == '0 && rx_data_i[7:0] != 8'h9C) |=> !status_dev_a_o[FLAG_BIT]); // R7
  AST_CLR_B: assert property (@(posedge clk) disable iff (rst)
    (rd_dev_b_i && !los_i && aux_fault_i == '0 && rx_data_i[7:0] != 8'h9C) |=> !status_dev_b_o[FLAG_BIT]); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status_dev_a_o & ~FLAG_MASK) == '0 && (status_dev_b_o & ~FLAG_MASK) == '0)); // R8
endmodule

bind link_fault_reporter lfr_chk #(.AUX_W(AUX_W), .REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_chk (.*);

// File: tb/sim_link_fault_reporter.sv
module sim_link_fault_reporter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rxd = '0;
  logic [7:0]  rxs = '0;
  logic        los = 1'b0;
  logic [1:0]  aux = '0;
  logic        rda = 1'b0, rdb = 1'b0;
  logic [31:0] od;
  logic [7:0]  os;
  logic [15:0] sa, sb;

  int checks = 0, failures = 0;
  bit ef_a = 1'b0, ef_b = 1'b0;

  localparam logic [31:0] LF_D = 32'h0100009C;
  localparam logic [7:0]  LF_S = 8'h03;
  localparam logic [31:0] RF_D = 32'h0200009C;

  always #10 clk = ~clk;

  link_fault_reporter u0 (
    .clk(clk), .rst(rst), .rx_data_i(rxd), .rx_side_i(rxs), .los_i(los),
    .aux_fault_i(aux), .rd_dev_a_i(rda), .rd_dev_b_i(rdb),
    .out_data_o(od), .out_side_o(os), .status_dev_a_o(sa), .status_dev_b_o(sb)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_lf_col(input logic [31:0] d, input logic [7:0] s);
    return (d == LF_D) && (s == LF_S);
  endfunction

  task automatic step(input logic [31:0] d, input logic [7:0] s, input logic l,
                      input logic [1:0] a, input logic ra, input logic rb);
    bit lf, cond, na, nb;
    string ltag, stag_a, stag_b;
    logic [31:0] ed;
    logic [7:0]  es;
    rxd = d; rxs = s; los = l; aux = a; rda = ra; rdb = rb;
    @(negedge clk);
    lf   = l | (|a);
    cond = lf | is_lf_col(d, s);
    ed   = lf ? LF_D : d;
    es   = lf ? LF_S : s;
    na   = ra ? cond : (ef_a | cond);
    nb   = rb ? cond : (ef_b | cond);
    ltag = lf ? ((a != 0 && !l) ? "R5 column" : "R2 column") : "R3 column";
    chk({od, os} == {ed, es}, ltag, {24'd0, od, os}, {24'd0, ed, es});
    if (ra) stag_a = "R7 flag A";
    else if (is_lf_col(d, s)) stag_a = "R4 flag A";
    else if (d[7:0] == 8'h9C) stag_a = "R9 flag A";
    else if (a != 0) stag_a = "R5 flag A";
    else stag_a = "R6 flag A";
    if (rb) stag_b = "R7 flag B";
    else if (is_lf_col(d, s)) stag_b = "R4 flag B";
    else if (d[7:0] == 8'h9C) stag_b = "R9 flag B";
    else stag_b = "R6 flag B";
    chk(sa[7] == na, stag_a, 64'(sa[7]), 64'(na));
    chk(sb[7] == nb, stag_b, 64'(sb[7]), 64'(nb));
    chk((sa & 16'hFF7F) == 0 && (sb & 16'hFF7F) == 0, "R8 upper bits", {32'd0, sa, sb}, 64'd0);
    ef_a = na; ef_b = nb;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(od == 0 && os == 0 && sa == 0 && sb == 0, "R1 reset", {od, os, 8'd0, sa[7], sb[7]}, 64'd0);
    rst = 1'b0;
    // directed corners
    step(32'hDEADBEEF, 8'hA5, 1'b1, 2'b00, 1'b0, 1'b0); // R2: substitute, flags set
    step(32'h11223344, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0); // R6 hold
    step(32'h55667788, 8'h0F, 1'b0, 2'b00, 1'b0, 1'b0); // R6 hold
    step(32'h00000000, 8'h00, 1'b0, 2'b00, 1'b1, 1'b0); // R7 A clears, B holds
    step(32'h12345678, 8'h00, 1'b1, 2'b00, 1'b0, 1'b1); // R7 B read during fault stays set
    step(32'h0, 8'h0, 1'b0, 2'b00, 1'b1, 1'b1);         // R7 clear both
    step(32'hCAFEF00D, 8'h30, 1'b0, 2'b10, 1'b0, 1'b0); // R5 aux fault
    step(32'h0, 8'h0, 1'b0, 2'b00, 1'b1, 1'b1);
    step(RF_D, LF_S, 1'b0, 2'b00, 1'b0, 1'b0);          // R3 remote passes, R4 no set
    step(LF_D, LF_S, 1'b0, 2'b00, 1'b0, 1'b0);          // R4 local column sets
    step(32'h0, 8'h0, 1'b0, 2'b00, 1'b1, 1'b1);
    step(LF_D, 8'h43, 1'b0, 2'b00, 1'b0, 1'b0);         // R9 lane 3 side bit wrong
    step(LF_D, 8'h02, 1'b0, 2'b00, 1'b0, 1'b0);         // R9 lane 0 side bit wrong
    step(32'h0101009C, LF_S, 1'b0, 2'b00, 1'b0, 1'b0);  // R9 lane 2 byte wrong
    step(LF_D, LF_S, 1'b0, 2'b00, 1'b1, 1'b0);          // R7 read while column present
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [7:0]  s;
      int          pick;
      pick = int'($urandom % 16);
      d = $urandom;
      s = 8'($urandom);
      if (pick < 2) begin d = LF_D; s = LF_S; end
      else if (pick == 2) begin d = RF_D; s = LF_S; end
      else if (pick == 3) begin
        int b;
        b = int'($urandom % 40);
        d = LF_D; s = LF_S;
        if (b < 32) d[b] = ~d[b]; else s[b-32] = ~s[b-32];
      end
      step(d, s, ($urandom % 12) == 0, {($urandom % 16) == 0, ($urandom % 16) == 0},
           ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule